// File: doc/BRIEF.md
# Inter-Message Gap Timer

This block sets the quiet time a command-response bus controller leaves between two messages. When a message finishes on the bus, the timer loads a gap length and counts it down on one-microsecond ticks. The gap length is either a default held in a control register or a value carried by the message itself. While the gap runs, the memory engine performs the block reads and writes that belong between messages. The timer counts their completion strobes and does not release the next message until all six are in. The interval that results is therefore the longer of the programmed gap and the memory overhead.

After the gap, two optional extensions may follow. A delay request adds a second microsecond countdown. A wait request holds the release until an external trigger arrives. The only output is a single-cycle go pulse that allows the sequencer to start the next message. There is no data stream: every pin is a plain control strobe or a level, and nothing applies back-pressure.

Top module: `msg_gap_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all counters and pending requests and returns the timer to idle. `go` is low in the cycle after every reset edge, and no `go` occurs until a new `eom` is accepted.
- R2: `eom` is accepted only while the timer is idle. Acceptance loads the gap counter with `msg_gap` when `msg_gap_en` is 1, and with `dflt_gap` otherwise. An `eom` that arrives while a gap, delay or wait is in progress has no effect.
- R3: The gap counter drops by one on each `us_tick` while it is non-zero and stays put otherwise. A tick in the same cycle as a load is lost to the load.
- R4: A release needs six `mem_done` strobes after acceptance. A strobe in the accepting cycle counts as the first. Strobes beyond the sixth, and strobes while idle (other than in the accepting cycle), are not counted.
- R5: A gap value of 0 means no programmed gap, so only the memory overhead applies. With a tick and a strobe in every cycle, `go` is seen max(G,5)+2 rising edges after the edge that accepts `eom`, counting that edge as the first.
- R6: `go` is high for exactly one cycle. It rises in the cycle after the edge at which the gap counter is zero, six strobes have been counted and no extension is pending. There is at most one `go` per accepted `eom`.
- R7: `dly_req` during the gap captures `dly_val`. Once the gap completes, a delay phase runs until that value has been ticked down to 0, and `go` follows one edge after it reaches 0. A captured value of 0 adds no time. The last request in a gap wins.
- R8: `wait_req` during the gap makes the timer enter a wait phase after the gap and any delay. `go` follows one edge after `wait_trig` is sampled in that phase. A `wait_trig` seen before the wait phase is ignored.
- R9: Delay and wait requests are taken only in gap cycles before the completion edge. Requests while idle, in the delay or wait phase, or in the cycle the gap completes have no effect on when `go` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| dflt_gap | input | GAP_W | Default gap in microseconds, from the control register |
| msg_gap | input | GAP_W | Gap carried by the message that just ended |
| msg_gap_en | input | 1 | 1 selects `msg_gap`, 0 selects `dflt_gap` |
| eom | input | 1 | Message-ended strobe |
| mem_done | input | 1 | One between-message memory access finished |
| dly_req | input | 1 | Delay instruction request |
| dly_val | input | GAP_W | Delay length in microseconds |
| wait_req | input | 1 | Wait instruction request |
| wait_trig | input | 1 | External trigger that ends a wait |
| go | output | 1 | One-cycle release for the next message |

## Verification
Two pairs of events can land on the same edge. The first pair is a message ending together with a memory-access strobe or a tick: the strobe must count as the first access, and the tick must lose to the load. The second pair is the gap completing together with a late delay or wait request, which must be dropped. The bench provokes both with dense random strobes, ticks and requests, and with directed runs that hold the tick and strobe high from the accepting edge onward. A cycle-level reference model in the bench decides, on every cycle, whether `go` must be high.

// File: rtl/img_pkg.sv
package img_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GAP  = 2'd1,
    PH_DLY  = 2'd2,
    PH_WAIT = 2'd3
  } img_phase_e;
endpackage

// File: rtl/img_tick_cnt.sv
module img_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         run,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && tick && !zero) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && run && tick && !zero) |=> (cnt == $past(cnt) - 1'b1)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt)); // R3
endmodule

// File: rtl/img_acc_cnt.sv
module img_acc_cnt #(
  parameter int NUM_ACC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic strobe,
  input  logic armed,
  output logic full
);
  localparam int AW = $clog2(NUM_ACC + 1);
  localparam logic [AW-1:0] TOP = AW'(NUM_ACC);

  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (restart)                 cnt <= strobe ? AW'(1) : '0;
    else if (armed && strobe && !full) cnt <= cnt + 1'b1;
  end

  assign full = (cnt == TOP);

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP); // R4
  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!restart && !armed) |=> $stable(cnt)); // R4
endmodule

// File: rtl/img_gap_fsm.sv
module img_gap_fsm
  import img_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       eom,
  input  logic       gap_zero,
  input  logic       acc_full,
  input  logic       dly_zero,
  input  logic       dly_req,
  input  logic       wait_req,
  input  logic       wait_trig,
  output img_phase_e phase,
  output logic       accept_eom,
  output logic       dly_load,
  output logic       go
);
  logic dly_pend, wait_pend, go_q, gap_done, take_req;

  assign accept_eom = (phase == PH_IDLE) && eom;
  assign gap_done   = (phase == PH_GAP) && gap_zero && acc_full;
  assign take_req   = (phase == PH_GAP) && !gap_done;
  assign dly_load   = take_req && dly_req;
  assign go         = go_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      dly_pend  <= 1'b0;
      wait_pend <= 1'b0;
      go_q      <= 1'b0;
    end else begin
      go_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (eom) begin
            phase     <= PH_GAP;
            dly_pend  <= 1'b0;
            wait_pend <= 1'b0;
          end
        end
        PH_GAP: begin
          if (gap_done) begin
            if (dly_pend && !dly_zero) phase <= PH_DLY;
            else if (wait_pend)        phase <= PH_WAIT;
            else begin
              phase <= PH_IDLE;
              go_q  <= 1'b1;
            end
          end else begin
            if (dly_req)  dly_pend  <= 1'b1;
            if (wait_req) wait_pend <= 1'b1;
          end
        end
        PH_DLY: begin
          if (dly_zero) begin
            if (wait_pend) phase <= PH_WAIT;
            else begin
              phase <= PH_IDLE;
              go_q  <= 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (wait_trig) begin
            phase <= PH_IDLE;
            go_q  <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (rst)
    go |=> !go); // R6
  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT && !wait_trig) |=> !go); // R8
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> !go); // R1
  AST_GO_IDLE_NEXT: assert property (@(posedge clk) disable iff (rst)
    go |-> (phase == PH_IDLE || phase == PH_GAP)); // R6
endmodule

// File: rtl/msg_gap_timer.sv
module msg_gap_timer
  import img_pkg::*;
#(
  parameter int GAP_W   = 16,
  parameter int NUM_ACC = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick,
  input  logic [GAP_W-1:0] dflt_gap,
  input  logic [GAP_W-1:0] msg_gap,
  input  logic             msg_gap_en,
  input  logic             eom,
  input  logic             mem_done,
  input  logic             dly_req,
  input  logic [GAP_W-1:0] dly_val,
  input  logic             wait_req,
  input  logic             wait_trig,
  output logic             go
);
  img_phase_e       phase;
  logic             accept_eom, dly_load;
  logic             gap_zero, dly_zero, acc_full;
  logic [GAP_W-1:0] gap_pick;

  assign gap_pick = msg_gap_en ? msg_gap : dflt_gap;

  img_tick_cnt #(.W(GAP_W)) u_gap_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (accept_eom),
    .load_val (gap_pick),
    .tick     (us_tick),
    .run      (1'b1),
    .zero     (gap_zero)
  );

  img_tick_cnt #(.W(GAP_W)) u_dly_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (dly_load),
    .load_val (dly_val),
    .tick     (us_tick),
    .run      (phase == PH_DLY),
    .zero     (dly_zero)
  );

  img_acc_cnt #(.NUM_ACC(NUM_ACC)) u_acc_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (accept_eom),
    .strobe  (mem_done),
    .armed   (phase == PH_GAP),
    .full    (acc_full)
  );

  img_gap_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .eom        (eom),
    .gap_zero   (gap_zero),
    .acc_full   (acc_full),
    .dly_zero   (dly_zero),
    .dly_req    (dly_req),
    .wait_req   (wait_req),
    .wait_trig  (wait_trig),
    .phase      (phase),
    .accept_eom (accept_eom),
    .dly_load   (dly_load),
    .go         (go)
  );

  AST_GO_AFTER_ACC: assert property (@(posedge clk) disable iff (rst)
    go |-> acc_full); // R4
  AST_GO_GAP_SPENT: assert property (@(posedge clk) disable iff (rst)
    go |-> gap_zero); // R5
  AST_BUSY_EOM_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (eom && phase != PH_IDLE) |=> !$rose(phase == PH_GAP)); // R2
endmodule

// File: tb/tb_msg_gap_timer.sv
module tb_msg_gap_timer;
  localparam int GW    = 16;
  localparam int NACC  = 6;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst = 1'b1, us_tick = 1'b0, eom = 1'b0, msg_gap_en = 1'b0;
  logic mem_done = 1'b0, dly_req = 1'b0, wait_req = 1'b0, wait_trig = 1'b0;
  logic [GW-1:0] dflt_gap = '0, msg_gap = '0, dly_val = '0;
  logic go;

  always #4 clk = ~clk;

  msg_gap_timer #(.GAP_W(GW), .NUM_ACC(NACC)) dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .dflt_gap(dflt_gap), .msg_gap(msg_gap),
    .msg_gap_en(msg_gap_en), .eom(eom), .mem_done(mem_done), .dly_req(dly_req),
    .dly_val(dly_val), .wait_req(wait_req), .wait_trig(wait_trig), .go(go)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  int m_st = 0, m_acc = 0, o_st = 0, o_acc = 0;
  logic [GW-1:0] m_gap = '0, m_dly = '0, o_gap = '0, o_dly = '0;
  logic m_dp = 1'b0, m_wp = 1'b0, m_go = 1'b0, o_done = 1'b0;

  // cycle-level reference model built from the requirements
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_gap = '0; m_acc = 0; m_dly = '0; m_dp = 1'b0; m_wp = 1'b0; m_go = 1'b0;
    end else begin
      o_st = m_st; o_gap = m_gap; o_acc = m_acc; o_dly = m_dly;
      o_done = (o_st == 1) && (o_gap == 0) && (o_acc == NACC);
      m_go = 1'b0;
      if (o_st == 0 && eom) begin
        m_gap = msg_gap_en ? msg_gap : dflt_gap;
        m_acc = mem_done ? 1 : 0;
      end else begin
        if (us_tick && o_gap != 0) m_gap = o_gap - 1'b1;
        if (o_st == 1 && mem_done && o_acc < NACC) m_acc = o_acc + 1;
      end
      if (o_st == 1 && !o_done && dly_req) m_dly = dly_val;
      else if (o_st == 2 && us_tick && o_dly != 0) m_dly = o_dly - 1'b1;
      case (o_st)
        0: if (eom) begin m_st = 1; m_dp = 1'b0; m_wp = 1'b0; end
        1: begin
          if (o_done) begin
            if (m_dp && o_dly != 0) m_st = 2;
            else if (m_wp) m_st = 3;
            else begin m_st = 0; m_go = 1'b1; end
          end else begin
            if (dly_req) m_dp = 1'b1;
            if (wait_req) m_wp = 1'b1;
          end
        end
        2: if (o_dly == 0) begin
             if (m_wp) m_st = 3;
             else begin m_st = 0; m_go = 1'b1; end
           end
        3: if (wait_trig) begin m_st = 0; m_go = 1'b1; end
        default: m_st = 0;
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    check(tag, go, m_go, "go against model");
    if (cyc > LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic quiet();
    us_tick = 0; mem_done = 0; eom = 0; dly_req = 0; wait_req = 0; wait_trig = 0;
  endtask

  // tick and strobe every cycle; measure edges from accepting edge to go
  task automatic lat_case(input int g, input bit use_msg, input int d, input bit d_on,
                          input bit xeom, input string req);
    int k;
    int exp;
    @(negedge clk);
    tag = req;
    us_tick = 1; mem_done = 1; msg_gap_en = use_msg;
    if (use_msg) begin msg_gap = GW'(g); dflt_gap = GW'(g + 7); end
    else begin dflt_gap = GW'(g); msg_gap = GW'(g + 9); end
    eom = 1;
    @(negedge clk);
    eom = 0;
    if (d_on) begin dly_req = 1; dly_val = GW'(d); end
    k = 1;
    while (!go && k < 200) begin
      @(negedge clk);
      k++;
      dly_req = 0;
      eom = (xeom && k == 3);
      if (xeom && k == 3) begin dflt_gap = 16'd40; msg_gap = 16'd40; end
    end
    eom = 0;
    exp = ((g > NACC - 1) ? g : NACC - 1) + 2 + ((d_on && d > 0) ? d + 1 : 0);
    check(req, k, exp, "edges from eom to go");
    @(negedge clk);
    check("R6", go, 0, "go width one cycle");
    quiet();
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check("R1", go, 0, "go during reset");
    rst = 0;
    repeat (4) @(negedge clk);
    check("R1", go, 0, "go idle after reset");

    lat_case(0, 0, 0, 0, 0, "R5");
    lat_case(3, 1, 0, 0, 0, "R5");
    lat_case(5, 0, 0, 0, 0, "R3");
    lat_case(6, 1, 0, 0, 0, "R2");
    lat_case(12, 0, 0, 0, 0, "R5");
    lat_case(9, 0, 0, 0, 1, "R2");
    lat_case(2, 0, 4, 1, 0, "R7");
    lat_case(2, 1, 0, 1, 0, "R7");

    // R9: requests while idle leave the next gap unchanged
    @(negedge clk);
    tag = "R9";
    dly_req = 1; dly_val = 16'd50; wait_req = 1;
    @(negedge clk);
    quiet();
    lat_case(3, 0, 0, 0, 0, "R9");

    // R4: slow strobes dominate a short gap
    @(negedge clk);
    tag = "R4";
    dflt_gap = 16'd1; msg_gap_en = 0; eom = 1; us_tick = 1;
    @(negedge clk);
    eom = 0;
    repeat (10) @(negedge clk);
    check("R4", go, 0, "no go without accesses");
    for (int i = 0; i < NACC; i++) begin
      mem_done = 1;
      @(negedge clk);
      mem_done = 0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    quiet();

    // R8: early trigger ignored, late trigger releases
    @(negedge clk);
    tag = "R8";
    dflt_gap = 16'd1; us_tick = 1; mem_done = 1; eom = 1;
    @(negedge clk);
    eom = 0; wait_req = 1;
    @(negedge clk);
    wait_req = 0; wait_trig = 1;
    @(negedge clk);
    wait_trig = 0;
    repeat (20) @(negedge clk);
    check("R8", go, 0, "go held in wait");
    wait_trig = 1;
    @(negedge clk);
    wait_trig = 0;
    check("R8", go, 1, "go one edge after trigger");
    quiet();
    repeat (3) @(negedge clk);

    // random mix, with a mid-run reset
    tag = "R6";
    for (int i = 0; i < 20000; i++) begin
      us_tick    = ($urandom % 4) == 0;
      mem_done   = ($urandom % 3) == 0;
      eom        = ($urandom % 6) == 0;
      msg_gap_en = $urandom % 2;
      dflt_gap   = GW'($urandom % 12);
      msg_gap    = GW'($urandom % 12);
      dly_req    = ($urandom % 15) == 0;
      dly_val    = GW'($urandom % 6);
      wait_req   = ($urandom % 20) == 0;
      wait_trig  = ($urandom % 8) == 0;
      rst        = (i >= 10000 && i < 10003);
      @(negedge clk);
      if (rst) check("R1", go, 0, "go while reset held");
    end
    rst = 0;
    quiet();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule